// File: doc/BRIEF.md
# Trimmed One-Second Timebase

This block divides a free-running oscillator clock down to a one-second tick and lets the tick rate be trimmed digitally. It counts a nominal number of oscillator cycles per second. It groups seconds into minutes and minutes into a repeating 64-minute window. In a chosen set of minutes at the front of each window, it stretches or shrinks exactly one second by a fixed number of oscillator cycles. Averaged over the window, this gives a correction that is set by a 5-bit magnitude and a direction bit.

A timekeeping datapath uses the three markers. The second tick advances the seconds field, the minute marker shows that a minute has rolled over, and the window marker shows where a 64-minute calibration window ends. A stop input freezes the whole timebase so that downstream logic can hold the time steady. Every marker is a single-cycle strobe in the oscillator domain. For simulation, the cycles-per-second and seconds-per-minute counts can be reduced through parameters.

Top module: `trim_timebase`

## Requirements
- R1: An unadjusted second lasts exactly CYC_PER_SEC non-stopped oscillator cycles. `sec_tick_o` is high for one cycle, on the last cycle of each second.
- R2: `min_tick_o` is high only together with the `sec_tick_o` that ends second SEC_PER_MIN-1 of a minute. `win_tick_o` is high only together with the `min_tick_o` that ends minute 63 of the 64-minute window.
- R3: The only second that can be adjusted is second 0 of a minute. It is adjusted exactly in minutes m (numbered 0 to 63 within the window) for which m < 2 * magnitude.
- R4: When the direction bit is 1, the adjusted second is SHORTEN (128) cycles shorter than nominal. When the direction bit is 0, it is LENGTHEN (256) cycles longer.
- R5: A magnitude of 0 adjusts no minute. A magnitude of 31 adjusts minutes 0 to 61, and minutes 62 and 63 are never adjusted.
- R6: The magnitude and direction are sampled on the first non-stopped cycle after reset and on the cycle that raises `win_tick_o`. A change at any other time has no effect until the next window.
- R7: While `stop_i` is high, all counters and the sampled calibration hold their values and no marker is raised. Counting resumes from the held state.
- R8: While `rst_n` is low, all markers are low, and the block restarts at cycle 0, second 0, minute 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock; one count per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_i | input | 1 | Freeze counters and suppress markers |
| cal_mag_i | input | 5 | Trim magnitude; adjusts 2*value minutes per window |
| cal_pos_i | input | 1 | Trim direction: 1 shortens, 0 lengthens |
| sec_tick_o | output | 1 | One-cycle strobe at the end of every second |
| min_tick_o | output | 1 | One-cycle strobe at the end of every minute |
| win_tick_o | output | 1 | One-cycle strobe at the end of each 64-minute window |

## Verification
The checker watches on every cycle that the markers nest correctly and that nothing ticks while stopped. It also checks that the cycle counter holds during a stop, that the sampled calibration changes only just after a sampling cycle, and that every second has one of the three legal lengths. Those properties cannot show which minutes are adjusted or that a calibration change made in mid-window is deferred. The bench shows these through its scenarios. A reference model is compared on every cycle across four windows: shortened with magnitude 3, lengthened with magnitude 31, disabled, and shortened with magnitude 31. The bench also counts the adjusted seconds in each window from the tick spacing.

// File: rtl/tbc_pkg.sv
package tbc_pkg;
  localparam int CAL_W       = 5;
  localparam int MIN_W       = 6;
  localparam int WIN_MINUTES = 1 << MIN_W;

  typedef struct packed {
    logic             pos;
    logic [CAL_W-1:0] mag;
  } cal_t;
endpackage

// File: rtl/tbc_cycle_count.sv
module tbc_cycle_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             term,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign term   = (cnt_q == limit);
  assign cnt_en = run;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) begin
      if (term) cnt_d = '0;
      else      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/tbc_time_index.sv
module tbc_time_index #(
  parameter int SEC_PER_MIN = 60
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    adv,
  output logic                    first_sec,
  output logic                    last_sec,
  output logic                    last_min,
  output logic [tbc_pkg::MIN_W-1:0] min_idx
);
  localparam int SEC_W = (SEC_PER_MIN > 1) ? $clog2(SEC_PER_MIN) : 1;
  localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SEC_PER_MIN - 1);
  localparam logic [tbc_pkg::MIN_W-1:0] MIN_LAST = tbc_pkg::MIN_W'(tbc_pkg::WIN_MINUTES - 1);

  logic [SEC_W-1:0]          sec_q, sec_d;
  logic [tbc_pkg::MIN_W-1:0] min_q, min_d;
  logic                      sec_en, min_en;

  assign first_sec = (sec_q == '0);
  assign last_sec  = (sec_q == SEC_LAST);
  assign last_min  = (min_q == MIN_LAST);
  assign sec_en    = adv;
  assign min_en    = adv & last_sec;

  always_comb begin
    sec_d = sec_q;
    if (sec_en) sec_d = last_sec ? '0 : sec_q + 1'b1;
  end

  always_comb begin
    min_d = min_q;
    if (min_en) min_d = last_min ? '0 : min_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sec_q <= '0;
    else if (sec_en) sec_q <= sec_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      min_q <= '0;
    else if (min_en) min_q <= min_d;
  end

  assign min_idx = min_q;
endmodule

// File: rtl/tbc_cal_sched.sv
module tbc_cal_sched #(
  parameter int CYC_PER_SEC = 32768,
  parameter int SHORTEN     = 128,
  parameter int LENGTHEN    = 256,
  parameter int CNT_W       = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      run,
  input  logic                      win_end,
  input  tbc_pkg::cal_t             cal_i,
  input  logic                      first_sec,
  input  logic [tbc_pkg::MIN_W-1:0] min_idx,
  output logic [CNT_W-1:0]          limit,
  output logic                      load_o,
  output tbc_pkg::cal_t             cal_q_o
);
  localparam logic [CNT_W-1:0] LIM_NOM   = CNT_W'(CYC_PER_SEC - 1);
  localparam logic [CNT_W-1:0] LIM_SHORT = CNT_W'(CYC_PER_SEC - 1 - SHORTEN);
  localparam logic [CNT_W-1:0] LIM_LONG  = CNT_W'(CYC_PER_SEC - 1 + LENGTHEN);

  tbc_pkg::cal_t cal_q;
  logic          pend_q, pend_d;
  logic          load;
  logic          adj_sec;
  logic [tbc_pkg::MIN_W:0] span;

  // pending flag makes the first active cycle after reset a sampling point
  assign load = run & (pend_q | win_end);

  always_comb begin
    pend_d = pend_q;
    if (run) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pend_q <= 1'b1;
    else if (run) pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cal_q <= '0;
    else if (load) cal_q <= cal_i;
  end

  // adjusted minutes: 0 .. 2*mag-1 (mag of 31 reaches minute 61)
  assign span    = {1'b0, cal_q.mag, 1'b0};
  assign adj_sec = first_sec & ({1'b0, min_idx} < span);

  always_comb begin
    limit = LIM_NOM;
    if (adj_sec) limit = cal_q.pos ? LIM_SHORT : LIM_LONG;
  end

  assign load_o  = load;
  assign cal_q_o = cal_q;
endmodule

// File: rtl/trim_timebase.sv
module trim_timebase #(
  parameter int CYC_PER_SEC = 32768,
  parameter int SEC_PER_MIN = 60,
  parameter int SHORTEN     = 128,
  parameter int LENGTHEN    = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stop_i,
  input  logic [4:0] cal_mag_i,
  input  logic       cal_pos_i,
  output logic       sec_tick_o,
  output logic       min_tick_o,
  output logic       win_tick_o
);
  localparam int CNT_W = $clog2(CYC_PER_SEC + LENGTHEN);

  logic                      run;
  logic                      term;
  logic [CNT_W-1:0]          limit;
  logic [CNT_W-1:0]          cyc_count;
  logic                      first_sec, last_sec, last_min;
  logic [tbc_pkg::MIN_W-1:0] min_idx;
  logic                      cal_load;
  tbc_pkg::cal_t             cal_in, cal_q;
  logic                      sec_end, min_end, win_end;

  assign run     = ~stop_i;
  assign cal_in  = '{pos: cal_pos_i, mag: cal_mag_i};
  assign sec_end = run & term;
  assign min_end = sec_end & last_sec;
  assign win_end = min_end & last_min;

  tbc_cycle_count #(.CNT_W(CNT_W)) u_cycles (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .limit (limit),
    .term  (term),
    .count (cyc_count)
  );

  tbc_time_index #(.SEC_PER_MIN(SEC_PER_MIN)) u_index (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (sec_end),
    .first_sec (first_sec),
    .last_sec  (last_sec),
    .last_min  (last_min),
    .min_idx   (min_idx)
  );

  tbc_cal_sched #(
    .CYC_PER_SEC (CYC_PER_SEC),
    .SHORTEN     (SHORTEN),
    .LENGTHEN    (LENGTHEN),
    .CNT_W       (CNT_W)
  ) u_sched (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .win_end   (win_end),
    .cal_i     (cal_in),
    .first_sec (first_sec),
    .min_idx   (min_idx),
    .limit     (limit),
    .load_o    (cal_load),
    .cal_q_o   (cal_q)
  );

  assign sec_tick_o = sec_end;
  assign min_tick_o = min_end;
  assign win_tick_o = win_end;
endmodule

// File: rtl/tbc_checker.sv
module tbc_checker #(
  parameter int CYC_PER_SEC = 32768,
  parameter int SHORTEN     = 128,
  parameter int LENGTHEN    = 256,
  parameter int CNT_W       = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stop_i,
  input logic             sec_tick_o,
  input logic             min_tick_o,
  input logic             win_tick_o,
  input logic             cal_load,
  input tbc_pkg::cal_t    cal_q,
  input logic [CNT_W-1:0] cyc_count
);
  int per_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       per_q <= 0;
    else if (!stop_i) per_q <= sec_tick_o ? 0 : per_q + 1;
  end

  // R2
  min_in_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    min_tick_o |-> sec_tick_o);

  // R2
  win_in_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_tick_o |-> min_tick_o);

  // R7
  stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |-> !sec_tick_o);

  // R7
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> $stable(cyc_count));

  // R6
  cal_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_q != $past(cal_q)) |-> $past(cal_load));

  // R1 R4
  sec_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick_o |-> ((per_q + 1 == CYC_PER_SEC) ||
                    (per_q + 1 == CYC_PER_SEC - SHORTEN) ||
                    (per_q + 1 == CYC_PER_SEC + LENGTHEN)));
endmodule

bind trim_timebase tbc_checker #(
  .CYC_PER_SEC (CYC_PER_SEC),
  .SHORTEN     (SHORTEN),
  .LENGTHEN    (LENGTHEN),
  .CNT_W       (CNT_W)
) u_tbc_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .stop_i     (stop_i),
  .sec_tick_o (sec_tick_o),
  .min_tick_o (min_tick_o),
  .win_tick_o (win_tick_o),
  .cal_load   (cal_load),
  .cal_q      (cal_q),
  .cyc_count  (cyc_count)
);

// File: tb/trim_timebase_bench.sv
`timescale 1ns/1ps
module trim_timebase_bench;
  localparam int CPS   = 200;
  localparam int SPM   = 2;
  localparam int SHORT = 128;
  localparam int LONG  = 256;
  localparam int RUN_CYCLES = 111000;
  localparam int WDOG_CYCLES = 150000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       stop_i;
  logic [4:0] cal_mag_i;
  logic       cal_pos_i;
  logic       sec_tick_o, min_tick_o, win_tick_o;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  // reference state
  int m_cyc, m_sec, m_min, m_mag, m_pos;
  bit m_pend;
  // tick-spacing bookkeeping from the outputs
  int per, n_short, n_long, win_idx;
  int exp_short [4] = '{6, 0, 0, 62};
  int exp_long  [4] = '{0, 62, 0, 0};

  always #2.5 clk = ~clk;

  trim_timebase #(
    .CYC_PER_SEC (CPS),
    .SEC_PER_MIN (SPM),
    .SHORTEN     (SHORT),
    .LENGTHEN    (LONG)
  ) u_trim_timebase (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop_i     (stop_i),
    .cal_mag_i  (cal_mag_i),
    .cal_pos_i  (cal_pos_i),
    .sec_tick_o (sec_tick_o),
    .min_tick_o (min_tick_o),
    .win_tick_o (win_tick_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int model_limit();
    int lim = CPS - 1;
    if (m_sec == 0 && m_min < 2 * m_mag) lim = m_pos ? lim - SHORT : lim + LONG;
    return lim;
  endfunction

  task automatic apply_stim(input int t);
    if (t == 5) rst_n = 1'b1;
    if (t == 3000) stop_i = 1'b1;
    if (t == 3050) stop_i = 1'b0;
    if (t == 5000)  begin cal_mag_i = 5'd31; cal_pos_i = 1'b0; end
    if (t == 40000) begin cal_mag_i = 5'd0;  cal_pos_i = 1'b1; end
    if (t == 70000) stop_i = 1'b1;
    if (t == 70010) stop_i = 1'b0;
    if (t == 80000) begin cal_mag_i = 5'd31; cal_pos_i = 1'b1; end
  endtask

  task automatic model_step();
    bit term;
    if (!rst_n || stop_i) return;
    term = (m_cyc == model_limit());
    if (m_pend) begin m_mag = cal_mag_i; m_pos = cal_pos_i; m_pend = 0; end
    if (term) begin
      m_cyc = 0;
      if (m_sec == SPM - 1) begin
        m_sec = 0;
        if (m_min == 63) begin
          m_min = 0; m_mag = cal_mag_i; m_pos = cal_pos_i;
        end else m_min++;
      end else m_sec++;
    end else m_cyc++;
  endtask

  task automatic compare();
    bit es, em, ew;
    int act, exp;
    string tag;
    es = rst_n && !stop_i && (m_cyc == model_limit());
    em = es && (m_sec == SPM - 1);
    ew = em && (m_min == 63);
    act = {win_tick_o, min_tick_o, sec_tick_o};
    exp = {ew, em, es};
    if (!rst_n)                               tag = "R8 reset state";
    else if (stop_i)                          tag = "R7 stop";
    else if (em)                              tag = "R2 minute/window marker";
    else if (m_sec == 0 && m_min < 2 * m_mag) tag = "R4 adjusted second";
    else                                      tag = "R1 nominal second";
    check(act == exp, tag, act, exp);
  endtask

  task automatic spacing();
    if (!rst_n || stop_i) return;
    if (sec_tick_o) begin
      if (per + 1 == CPS - SHORT) n_short++;
      else if (per + 1 == CPS + LONG) n_long++;
      per = 0;
      if (win_tick_o) begin
        if (win_idx < 4) begin
          case (win_idx)
            0: check(n_short == exp_short[0] && n_long == 0, "R3 R6 window0 adjusted count",
                     n_short * 100 + n_long, exp_short[0] * 100);
            1: check(n_short == 0 && n_long == exp_long[1], "R4 R5 window1 lengthened count",
                     n_short * 100 + n_long, exp_long[1]);
            2: check(n_short == 0 && n_long == 0, "R5 R6 window2 no adjustment",
                     n_short * 100 + n_long, 0);
            default: check(n_short == exp_short[3] && n_long == 0, "R5 window3 shortened count",
                     n_short * 100 + n_long, exp_short[3] * 100);
          endcase
        end
        win_idx++;
        n_short = 0;
        n_long  = 0;
      end
    end else per++;
  endtask

  initial begin
    rst_n = 1'b0; stop_i = 1'b0; cal_mag_i = 5'd3; cal_pos_i = 1'b1;
    m_cyc = 0; m_sec = 0; m_min = 0; m_mag = 0; m_pos = 0; m_pend = 1;
    per = 0; n_short = 0; n_long = 0; win_idx = 0;
    for (int t = 0; t < RUN_CYCLES; t++) begin
      @(negedge clk);
      apply_stim(t);
      #0.5;
      compare();
      spacing();
      model_step();
    end
    check(win_idx == 4, "R2 window marker count", win_idx, 4);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (WDOG_CYCLES) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule